// File: doc/BRIEF.md
# Shared Parameter RAM Host Port

This block holds a 32-bit wide, word-indexed parameter RAM. Two agents share it: an internal engine that addresses whole words by index, and a host that sees the same storage as bytes. Host accesses may be 8, 16 or 32 bits wide at aligned byte addresses. The port turns each host access into a word index and a set of byte-lane enables, and places the selected bytes according to the endianness parameter. Engine index N is the word at host byte offset N×4.

The host address space appears twice. The top address bit selects a second, mirrored window. In that window a 32-bit access handles a signed 24-bit parameter. Reads return the low 24 bits of the word, sign-extended to 32. Writes change only the low 24 bits. The engine has priority over the single RAM. A host request that meets an engine request waits, and `h_ready` stays low until the engine releases the RAM.

Top module: `param_ram_host_port`

## Requirements
- R1: Host byte address A selects word index A[IDX_W+1:2]. Engine index N and host byte offset N×4 name the same word, for example index 0x101 and offset 0x404.
- R2: A 32-bit host access (h_size=2) at a 4-byte-aligned address writes all four bytes, or reads the whole word back unchanged.
- R3: In big-endian mode, a 16-bit access (h_size=1) at offset 0 uses bits 31:16 and one at offset 2 uses bits 15:0. Read data is right-aligned with zero upper bits, and a write leaves the other half of the word unchanged.
- R4: In big-endian mode, an 8-bit access (h_size=0) at offset b uses bits 31-8b down to 24-8b. Read data is right-aligned with zero upper bits, and a write changes that byte only.
- R5: A 16-bit access at an odd address, a 32-bit access that is not 4-byte aligned, or h_size=3 leaves memory unchanged. Its response carries h_err=1. Aligned accesses respond with h_err=0.
- R6: A 32-bit read with address bit IDX_W+2 set (the mirror window) returns bits 23:0 of the word with bit 23 copied into bits 31:24.
- R7: A 32-bit write in the mirror window updates bits 23:0 and leaves bits 31:24 unchanged.
- R8: 8- and 16-bit accesses in the mirror window behave as in the normal window, with no sign extension.
- R9: While e_req is high, h_ready is low and no host access is accepted. The waiting host access is accepted in the first cycle after e_req falls.
- R10: Host and engine requests raised in the same cycle are both served. An engine write completes first, and engine read data appears on e_rdata one cycle after the request.
- R11: After reset, h_rvalid and h_err are 0. Every accepted host access gives exactly one h_rvalid pulse, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_req | input | 1 | Host request, held until accepted |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | IDX_W+3 | Host byte address; top bit selects the mirror window |
| h_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: invalid |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_ready | output | 1 | Host access accepted at this edge when h_req is high |
| h_rvalid | output | 1 | Response valid |
| h_err | output | 1 | Response is an error |
| h_rdata | output | 32 | Host read data, right-aligned |
| e_req | input | 1 | Engine request (priority) |
| e_we | input | 1 | Engine write (1) or read (0) |
| e_idx | input | IDX_W | Engine word index |
| e_wdata | input | 32 | Engine write data |
| e_rdata | output | 32 | Engine read data, one cycle after request |

## Verification
The hardest case to reach is a host access that is raised in the same cycle as an engine write to the same word and then kept waiting across several engine cycles. The bench raises the engine request first and holds it for two cycles, then starts a host read of that word in the same cycle. It counts the cycles in which h_ready stays low and checks that the read returns the value the engine wrote. Misaligned writes are followed by a read of the target word, so the absence of side effects is checked at the ports.

// File: rtl/param_ram_host_port.sv
module param_ram_host_port #(
  parameter int IDX_W      = 9,
  parameter bit BIG_ENDIAN = 1'b1,
  localparam int DEPTH     = 1 << IDX_W,
  localparam int AW        = IDX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_req,
  input  logic             h_we,
  input  logic [AW-1:0]    h_addr,
  input  logic [1:0]       h_size,
  input  logic [31:0]      h_wdata,
  output logic             h_ready,
  output logic             h_rvalid,
  output logic             h_err,
  output logic [31:0]      h_rdata,
  input  logic             e_req,
  input  logic             e_we,
  input  logic [IDX_W-1:0] e_idx,
  input  logic [31:0]      e_wdata,
  output logic [31:0]      e_rdata
);

  logic [31:0] mem [DEPTH];

  wire             sew   = h_addr[AW-1];
  wire [IDX_W-1:0] h_idx = h_addr[IDX_W+1:2];
  wire [1:0]       off   = h_addr[1:0];
  wire             se32  = sew && (h_size == 2'd2);

  logic       misal;
  logic [2:0] nbytes;
  logic [3:0] base;
  always_comb begin
    case (h_size)
      2'd0:    begin misal = 1'b0;    nbytes = 3'd1; base = 4'b0001; end
      2'd1:    begin misal = off[0];  nbytes = 3'd2; base = 4'b0011; end
      2'd2:    begin misal = |off;    nbytes = 3'd4; base = 4'b1111; end
      default: begin misal = 1'b1;    nbytes = 3'd4; base = 4'b1111; end
    endcase
  end

  wire [1:0] lo    = BIG_ENDIAN ? 2'(3'd4 - nbytes - {1'b0, off}) : off;
  wire [3:0] lanes = se32 ? 4'b0111 : (base << lo);

  logic [31:0] wmask;
  always_comb
    for (int i = 0; i < 4; i++) wmask[8*i +: 8] = {8{lanes[i]}};

  assign h_ready = !e_req;
  wire h_fire = h_req && h_ready;

  always_ff @(posedge clk) begin
    if (e_req && e_we)
      mem[e_idx] <= e_wdata;
    else if (h_fire && h_we && !misal)
      mem[h_idx] <= (mem[h_idx] & ~wmask) | ((h_wdata << {lo, 3'b000}) & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_err    <= 1'b0;
    end else begin
      h_rvalid <= h_fire;
      h_err    <= h_fire && misal;
    end
  end

  logic [31:0] rd_word;
  logic [1:0]  rd_lo, rd_size;
  logic        rd_se;
  always_ff @(posedge clk) begin
    if (e_req && !e_we) e_rdata <= mem[e_idx];
    if (h_fire) begin
      rd_word <= mem[h_idx];
      rd_lo   <= lo;
      rd_size <= h_size;
      rd_se   <= se32;
    end
  end

  wire [31:0] rd_sh = rd_word >> {rd_lo, 3'b000};
  assign h_rdata = rd_se          ? {{8{rd_word[23]}}, rd_word[23:0]} :
                   rd_size == 2'd0 ? {24'b0, rd_sh[7:0]} :
                   rd_size == 2'd1 ? {16'b0, rd_sh[15:0]} : rd_word;

  // R5
  misal_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_ready && misal |=> h_rvalid && h_err);

  // R5
  aligned_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_ready && !misal |=> h_rvalid && !h_err);

  // R11
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && h_ready) |=> !h_rvalid);

  // R6
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_req && h_ready && !h_we && sew && h_size == 2'd2 |=>
      h_rdata[31:24] == {8{h_rdata[23]}});

endmodule

// File: tb/test_param_ram_host_port.sv
module test_param_ram_host_port;
  localparam int IDX_W = 9;
  localparam int AW    = IDX_W + 3;
  localparam logic [AW-1:0] SEW = AW'(1) << (AW - 1);

  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0;
  logic [AW-1:0] h_addr = '0;
  logic [1:0] h_size = '0;
  logic [31:0] h_wdata = '0;
  logic h_ready, h_rvalid, h_err;
  logic [31:0] h_rdata;
  logic e_req = 0, e_we = 0;
  logic [IDX_W-1:0] e_idx = '0;
  logic [31:0] e_wdata = '0, e_rdata;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  param_ram_host_port #(.IDX_W(IDX_W), .BIG_ENDIAN(1'b1)) i_param_ram_host_port (
    .clk, .rst_n, .h_req, .h_we, .h_addr, .h_size, .h_wdata, .h_ready,
    .h_rvalid, .h_err, .h_rdata, .e_req, .e_we, .e_idx, .e_wdata, .e_rdata);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic er, output int stalls);
    h_req = 1; h_we = we; h_addr = a; h_size = sz; h_wdata = wd;
    stalls = 0;
    #1;
    while (!h_ready) begin @(negedge clk); #1; stalls++; end
    @(posedge clk);
    @(negedge clk);
    h_req = 0;
    rd = h_rdata; er = h_err;
    checks++;
    if (h_rvalid !== 1'b1) begin
      fails++; $display("FAIL R11: actual rvalid %b expected 1", h_rvalid);
    end
    @(negedge clk);
    checks++;
    if (h_rvalid !== 1'b0) begin
      fails++; $display("FAIL R11: actual rvalid %b expected 0", h_rvalid);
    end
  endtask

  task automatic hw(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] d,
                    input logic exp_err, input string tag);
    logic [31:0] rd; logic er; int st;
    host(1'b1, a, sz, d, rd, er, st);
    chk(tag, 32'(er), 32'(exp_err));
  endtask

  task automatic hr(input logic [AW-1:0] a, input logic [1:0] sz,
                    input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic er; int st;
    host(1'b0, a, sz, '0, rd, er, st);
    chk(tag, rd, exp);
  endtask

  task automatic ew(input logic [IDX_W-1:0] i, input logic [31:0] d);
    e_req = 1; e_we = 1; e_idx = i; e_wdata = d;
    @(negedge clk);
    e_req = 0; e_we = 0;
  endtask

  task automatic er_(input logic [IDX_W-1:0] i, input logic [31:0] exp, input string tag);
    e_req = 1; e_we = 0; e_idx = i;
    @(negedge clk);
    e_req = 0;
    chk(tag, e_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R11 reset rvalid", 32'(h_rvalid), 0);
    chk("R11 reset err", 32'(h_err), 0);
  endtask

  task automatic t_index_map;
    ew(9'h101, 32'hCAFE_1234);
    hr(12'h404, 2'd2, 32'hCAFE_1234, "R1 engine->host");
    hw(12'h408, 2'd2, 32'h1122_3344, 1'b0, "R1 write err");
    er_(9'h102, 32'h1122_3344, "R1 host->engine");
  endtask

  task automatic t_word;
    hw(12'h010, 2'd2, 32'hA5A5_5A5A, 1'b0, "R2 write err");
    hr(12'h010, 2'd2, 32'hA5A5_5A5A, "R2 word readback");
  endtask

  task automatic t_half_byte;
    hw(12'h020, 2'd2, 32'h1122_3344, 1'b0, "R2 write err");
    hr(12'h020, 2'd1, 32'h0000_1122, "R3 half off0");
    hr(12'h022, 2'd1, 32'h0000_3344, "R3 half off2");
    hw(12'h022, 2'd1, 32'h0000_BEEF, 1'b0, "R3 write err");
    hr(12'h020, 2'd2, 32'h1122_BEEF, "R3 half write");
    hr(12'h020, 2'd0, 32'h0000_0011, "R4 byte off0");
    hr(12'h023, 2'd0, 32'h0000_00EF, "R4 byte off3");
    hw(12'h021, 2'd0, 32'h0000_0077, 1'b0, "R4 write err");
    hr(12'h020, 2'd2, 32'h1177_BEEF, "R4 byte write");
  endtask

  task automatic t_misaligned;
    hw(12'h022, 2'd2, 32'hDEAD_DEAD, 1'b1, "R5 word misaligned err");
    hw(12'h021, 2'd1, 32'h0000_DEAD, 1'b1, "R5 half odd err");
    hw(12'h020, 2'd3, 32'hDEAD_DEAD, 1'b1, "R5 size3 err");
    hr(12'h020, 2'd2, 32'h1177_BEEF, "R5 memory unchanged");
  endtask

  task automatic t_sign_window;
    hw(12'h030, 2'd2, 32'h0080_0001, 1'b0, "R6 write err");
    hr(SEW | 12'h030, 2'd2, 32'hFF80_0001, "R6 negative");
    hw(12'h034, 2'd2, 32'h7F7F_FFFF, 1'b0, "R6 write err");
    hr(SEW | 12'h034, 2'd2, 32'h007F_FFFF, "R6 positive");
    hw(12'h030, 2'd2, 32'hAB00_0000, 1'b0, "R7 write err");
    hw(SEW | 12'h030, 2'd2, 32'h1234_5678, 1'b0, "R7 window write err");
    hr(12'h030, 2'd2, 32'hAB34_5678, "R7 top byte kept");
    hr(SEW | 12'h030, 2'd0, 32'h0000_00AB, "R8 byte in window");
    hr(SEW | 12'h032, 2'd1, 32'h0000_5678, "R8 half in window");
  endtask

  task automatic t_contention;
    logic [31:0] rd; logic er; int st;
    e_req = 1; e_we = 1; e_idx = 9'h005; e_wdata = 32'h5EED_0BAD;
    fork
      begin repeat (2) @(negedge clk); e_req = 0; e_we = 0; end
      host(1'b0, 12'h014, 2'd2, '0, rd, er, st);
    join
    chk("R9 stall cycles", 32'(st), 32'd2);
    chk("R10 host read after engine write", rd, 32'h5EED_0BAD);
    er_(9'h005, 32'h5EED_0BAD, "R10 engine read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_index_map;
    t_word;
    t_half_byte;
    t_misaligned;
    t_sign_window;
    t_contention;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule